// File: doc/BRIEF.md
# Receive FIFO Inactivity Watchdog

This block watches the receive FIFOs of a multi-channel serial receiver and raises a flag when a channel holds characters that nobody has touched for a fixed number of bit times. It exists for the tail of a message: a few characters that never reach the normal fill threshold would otherwise wait unseen. Each channel has its own counter. The counter advances on that channel's bit-time tick while the channel is enabled and its FIFO holds data. When the count reaches the timeout, a sticky status bit is set.

Any FIFO traffic on a channel restarts its count and drops its status. Traffic means a character pushed in by the receiver, a pop by the host on the channel's own read port, or a pop through the shared global read port. A global read affects only the channel named by the current interrupt context; every other channel keeps counting. The status of each channel is gated by a per-channel mask to form a registered interrupt request, and the requests are also combined into one line.

Top module: `rx_idle_watchdog`

## Requirements
- R1: With its channel enabled and its FIFO non-empty, a channel's status bit goes high on the clock edge that samples the TIMEOUT-th bit tick counted since the last clear. It does not go high on any earlier edge. Cycles without a tick do not advance the count.
- R2: A push on a channel (push bit high for one cycle) zeroes that channel's count and clears its status at the next edge.
- R3: A pop on a channel's own read port zeroes that channel's count and clears its status at the next edge.
- R4: A global read with context value k (gread high, gread_ch = k) clears only channel k. All other channels keep their status and their count.
- R5: wd_irq[i] equals status[i] AND wd_mask[i], registered one cycle after the status. irq_any is the registered OR of the same products. A mask bit of 0 keeps that request low.
- R6: While a channel's enable bit is 0, its count is held at zero and its status is cleared. After it is enabled again, a full TIMEOUT ticks are needed to set the status.
- R7: Ticks that arrive while a channel's FIFO is empty are not counted. The count reached before the FIFO emptied is kept and resumes when data is present again.
- R8: Once set, the status stays high under any number of further ticks until a clearing event. The counter saturates and never wraps.
- R9: A synchronous reset clears every count, status bit and interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | NUM_CH | Per-channel bit-time tick, one cycle wide |
| fifo_nonempty | input | NUM_CH | Per-channel receive FIFO holds data |
| rx_push | input | NUM_CH | Per-channel character pushed into FIFO |
| rx_pop | input | NUM_CH | Per-channel pop on the channel's read port |
| gread | input | 1 | Pop through the shared global read port |
| gread_ch | input | CTX_W | Channel of the current interrupt context |
| wd_enable | input | NUM_CH | Per-channel watchdog enable |
| wd_mask | input | NUM_CH | Per-channel interrupt mask |
| wd_status | output | NUM_CH | Sticky timeout status per channel |
| wd_irq | output | NUM_CH | Masked interrupt request per channel |
| irq_any | output | 1 | OR of all masked requests |

## Verification
The bench builds the block with NUM_CH = 4 and TIMEOUT = 8. With these values every tick count from one to beyond saturation can be swept on every channel in few cycles. Every global-read context value can be tried against a full set of expired channels. Enable and mask patterns can also be combined with held counts on empty FIFOs. The expected state for each channel is derived from the tick count alone.

// File: rtl/rxwd_pkg.sv
package rxwd_pkg;

  typedef struct packed {
    logic push;
    logic pop;
    logic gsel;
  } rxwd_evt_t;

  function automatic int cnt_width(input int timeout);
    return $clog2(timeout + 1);
  endfunction

  function automatic int ctx_width(input int nch);
    return (nch > 1) ? $clog2(nch) : 1;
  endfunction

endpackage

// File: rtl/rxwd_evt_decode.sv
module rxwd_evt_decode
  import rxwd_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CTX_W  = ctx_width(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] rx_push,
  input  logic [NUM_CH-1:0] rx_pop,
  input  logic              gread,
  input  logic [CTX_W-1:0]  gread_ch,
  output rxwd_evt_t         evt [NUM_CH]
);

  logic [NUM_CH-1:0] gsel_vec;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    assign gsel_vec[i] = gread && (gread_ch == CTX_W'(i));
    assign evt[i].push = rx_push[i];
    assign evt[i].pop  = rx_pop[i];
    assign evt[i].gsel = gsel_vec[i];
  end

  AST_GREAD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gsel_vec)); // R4

endmodule

// File: rtl/rxwd_channel.sv
module rxwd_channel
  import rxwd_pkg::*;
#(
  parameter int TIMEOUT = 64,
  parameter int CW      = cnt_width(TIMEOUT)
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  logic      tick,
  input  logic      nonempty,
  input  rxwd_evt_t evt,
  output logic      status_o
);

  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);
  localparam logic [CW-1:0] TOP  = CW'(TIMEOUT);

  logic [CW-1:0] cnt_q;
  logic          st_q;
  logic          clr;
  logic          adv;

  assign clr = evt.push | evt.pop | evt.gsel;
  assign adv = tick & nonempty & ~st_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
      st_q  <= 1'b0;
    end else if (clr) begin
      cnt_q <= '0;
      st_q  <= 1'b0;
    end else if (adv) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) st_q <= 1'b1;
    end
  end

  assign status_o = st_q;

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= TOP); // R8

  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (st_q && en && !clr) |=> st_q); // R8

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    (en && clr) |=> (cnt_q == '0) && !st_q); // R2

  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt_q == '0) && !st_q); // R6

  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(st_q) |-> $past(tick && nonempty && en && !clr)); // R1

  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (en && !nonempty && !clr) |=> $stable(cnt_q)); // R7

endmodule

// File: rtl/rxwd_irq.sv
module rxwd_irq #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] status,
  input  logic [NUM_CH-1:0] mask,
  output logic [NUM_CH-1:0] irq,
  output logic              irq_any
);

  logic [NUM_CH-1:0] req;
  assign req = status & mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= '0;
      irq_any <= 1'b0;
    end else begin
      irq     <= req;
      irq_any <= |req;
    end
  end

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> !irq_any); // R5

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (status == '0) |=> (irq == '0)); // R5

endmodule

// File: rtl/rx_idle_watchdog.sv
module rx_idle_watchdog
  import rxwd_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int TIMEOUT = 64,
  parameter int CTX_W   = ctx_width(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] bit_tick,
  input  logic [NUM_CH-1:0] fifo_nonempty,
  input  logic [NUM_CH-1:0] rx_push,
  input  logic [NUM_CH-1:0] rx_pop,
  input  logic              gread,
  input  logic [CTX_W-1:0]  gread_ch,
  input  logic [NUM_CH-1:0] wd_enable,
  input  logic [NUM_CH-1:0] wd_mask,
  output logic [NUM_CH-1:0] wd_status,
  output logic [NUM_CH-1:0] wd_irq,
  output logic              irq_any
);

  localparam int CW = cnt_width(TIMEOUT);

  rxwd_evt_t evt [NUM_CH];

  rxwd_evt_decode #(.NUM_CH(NUM_CH), .CTX_W(CTX_W)) u_dec (
    .clk      (clk),
    .rst      (rst),
    .rx_push  (rx_push),
    .rx_pop   (rx_pop),
    .gread    (gread),
    .gread_ch (gread_ch),
    .evt      (evt)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    rxwd_channel #(.TIMEOUT(TIMEOUT), .CW(CW)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .en       (wd_enable[i]),
      .tick     (bit_tick[i]),
      .nonempty (fifo_nonempty[i]),
      .evt      (evt[i]),
      .status_o (wd_status[i])
    );
  end

  rxwd_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .status  (wd_status),
    .mask    (wd_mask),
    .irq     (wd_irq),
    .irq_any (irq_any)
  );

  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> (wd_status == '0) && (wd_irq == '0) && !irq_any); // R9

endmodule

// File: tb/rx_idle_watchdog_bench.sv
module rx_idle_watchdog_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int T  = 8;
  localparam int CW = 2;
  localparam logic [N-1:0] ALL = '1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  bit_tick = '0, fifo_nonempty = '0, rx_push = '0, rx_pop = '0;
  logic          gread = 1'b0;
  logic [CW-1:0] gread_ch = '0;
  logic [N-1:0]  wd_enable = '0, wd_mask = '0;
  logic [N-1:0]  wd_status, wd_irq;
  logic          irq_any;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_idle_watchdog #(.NUM_CH(N), .TIMEOUT(T), .CTX_W(CW)) u_rx_idle_watchdog (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .fifo_nonempty(fifo_nonempty),
    .rx_push(rx_push), .rx_pop(rx_pop), .gread(gread), .gread_ch(gread_ch),
    .wd_enable(wd_enable), .wd_mask(wd_mask), .wd_status(wd_status),
    .wd_irq(wd_irq), .irq_any(irq_any)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one cycle of stimulus from a negedge; returns at the next negedge.
  task automatic step(input logic [N-1:0] tk, input logic [N-1:0] ps,
                      input logic [N-1:0] pp, input logic gr, input int ctx);
    bit_tick = tk; rx_push = ps; rx_pop = pp; gread = gr; gread_ch = CW'(ctx);
    @(negedge clk);
    bit_tick = '0; rx_push = '0; rx_pop = '0; gread = 1'b0;
  endtask

  task automatic ticks(input logic [N-1:0] tk, input int n);
    for (int i = 0; i < n; i++) step(tk, '0, '0, 1'b0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk("R9 status", 32'(wd_status), 0);
    chk("R9 irq", 32'(wd_irq), 0);
    chk("R9 any", 32'(irq_any), 0);

    wd_enable = ALL; wd_mask = ALL; fifo_nonempty = ALL;

    // R1 / R8 sweep every channel across the timeout and beyond
    for (int c = 0; c < N; c++) begin
      step('0, ALL, '0, 1'b0, 0);
      for (int k = 1; k <= T + 3; k++) begin
        step(N'(1 << c), '0, '0, 1'b0, 0);
        chk((k > T) ? "R8 saturate" : "R1 timeout", 32'(wd_status),
            (k >= T) ? 32'(1 << c) : 0);
      end
      step('0, '0, '0, 1'b0, 0);
      chk("R5 irq follows", 32'(wd_irq), 32'(1 << c));
      chk("R1 idle no count", 32'(wd_status), 32'(1 << c));
    end

    // R2 / R3 push and pop clears on channel 1, channel 3 untouched
    step('0, ALL, '0, 1'b0, 0);
    ticks(4'b1010, T);
    chk("R1 both set", 32'(wd_status), 32'b1010);
    step('0, 4'b0010, '0, 1'b0, 0);
    chk("R2 push clears", 32'(wd_status), 32'b1000);
    ticks(4'b0010, T - 1);
    chk("R2 recount short", 32'(wd_status), 32'b1000);
    ticks(4'b0010, 1);
    chk("R2 recount full", 32'(wd_status), 32'b1010);
    step('0, '0, 4'b0010, 1'b0, 0);
    chk("R3 pop clears", 32'(wd_status), 32'b1000);
    ticks(4'b0010, T - 1);
    chk("R3 recount short", 32'(wd_status), 32'b1000);
    ticks(4'b0010, 1);
    chk("R3 recount full", 32'(wd_status), 32'b1010);

    // R4 global read clears only the context channel
    for (int k = 0; k < N; k++) begin
      ticks(ALL, T);
      chk("R4 all set", 32'(wd_status), 32'(ALL));
      step('0, '0, '0, 1'b1, k);
      chk("R4 context only", 32'(wd_status), 32'(ALL & ~N'(1 << k)));
      ticks(N'(1 << k), T - 1);
      chk("R4 others kept", 32'(wd_status), 32'(ALL & ~N'(1 << k)));
    end
    ticks(ALL, T);

    // R5 masking
    wd_mask = '0;
    step('0, '0, '0, 1'b0, 0);
    chk("R5 masked irq", 32'(wd_irq), 0);
    chk("R5 masked any", 32'(irq_any), 0);
    wd_mask = 4'b0101;
    step('0, '0, '0, 1'b0, 0);
    chk("R5 partial irq", 32'(wd_irq), 32'b0101);
    chk("R5 partial any", 32'(irq_any), 1);
    wd_mask = ALL;

    // R6 disable holds channel 2 idle
    wd_enable = 4'b1011;
    step('0, '0, '0, 1'b0, 0);
    chk("R6 disable clears", 32'(wd_status), 32'b1011);
    ticks(4'b0100, T + 2);
    chk("R6 no count", 32'(wd_status), 32'b1011);
    wd_enable = ALL;
    ticks(4'b0100, T - 1);
    chk("R6 restart short", 32'(wd_status), 32'b1011);
    ticks(4'b0100, 1);
    chk("R6 restart full", 32'(wd_status), 32'b1111);

    // R7 empty FIFO holds the count on channel 0
    step('0, ALL, '0, 1'b0, 0);
    fifo_nonempty = 4'b1110;
    ticks(4'b0001, T + 5);
    chk("R7 empty never", 32'(wd_status), 0);
    fifo_nonempty = ALL;
    ticks(4'b0001, 3);
    fifo_nonempty = 4'b1110;
    ticks(4'b0001, 10);
    chk("R7 held", 32'(wd_status), 0);
    fifo_nonempty = ALL;
    ticks(4'b0001, T - 4);
    chk("R7 resume short", 32'(wd_status), 0);
    ticks(4'b0001, 1);
    chk("R7 resume full", 32'(wd_status), 32'b0001);

    // R9 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    step('0, '0, '0, 1'b0, 0);
    chk("R9 rerun status", 32'(wd_status), 0);
    chk("R9 rerun irq", 32'({irq_any, wd_irq}), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule